// File: doc/BRIEF.md
# Saturating Numerically Controlled Oscillator

This block is the digital oscillator at the end of a clock-recovery loop. A signed control word from the loop filter is turned into a frequency word. The frequency word is added to a wrapping phase register every clock. The top bit of the phase register is a square-wave recovered clock, and a one-cycle strobe marks each wrap of the phase. Before the control word reaches the frequency mapping it is limited to a symmetric full-scale window.

The frequency word is the centre word plus the gain times the sum of the limited control and a signed offset. The offset lets the loop model, or cancel, the mismatch between the free-running rate and the incoming line rate. The result saturates at zero and at the largest word. When loss of signal is flagged, the control is forced to its mid value and the oscillator free-runs. A bang-bang mode pins the control to either end of the window, chosen by its sign. The centre, gain and offset are held in registers that change only on a load strobe. Out of reset they hold parameter defaults.

Top module: `nco_sat_top`

## Requirements
- R1: While reset is asserted, freq_o, phase_o, clk_o and wrap_o are all zero. The centre, gain and offset registers take the parameter defaults DEF_CENTER, DEF_GAIN and DEF_BIAS.
- R2: With los_i and bang_i low and |ctrl_i| < FULL_SCALE, the frequency word is center + gain * (ctrl_i + bias), computed from the registered configuration.
- R3: A control of zero with a zero offset yields exactly the centre word.
- R4: A control at or above +FULL_SCALE acts as +FULL_SCALE, and one at or below -FULL_SCALE acts as -FULL_SCALE. The offset is added after this limiting.
- R5: The frequency word saturates: a negative result gives 0, and a result above 2^FREQ_W-1 gives 2^FREQ_W-1.
- R6: While los_i is high, the effective control is 0 regardless of ctrl_i and bang_i, so the word is the free-running value center + gain * bias.
- R7: With bang_i high and los_i low, a control with sign bit 0 acts as +FULL_SCALE and one with sign bit 1 acts as -FULL_SCALE.
- R8: freq_o is registered. It reflects the inputs and the configuration present at the preceding rising clock edge.
- R9: At each edge, phase_o becomes (phase_o + freq_o) mod 2^PHASE_W, and clk_o equals bit PHASE_W-1 of phase_o.
- R10: wrap_o is high for exactly the cycle in which phase_o holds a value that came from an addition that overflowed 2^PHASE_W. Otherwise it is low.
- R11: center_i, gain_i and bias_i are ignored unless cfg_load_i is high at an edge. A load at an edge first affects the word computed at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| ctrl_i | input | CTRL_W | Signed control word from the loop filter |
| los_i | input | 1 | Loss of signal; forces free-running operation |
| bang_i | input | 1 | Bang-bang mode select |
| cfg_load_i | input | 1 | Load strobe for centre, gain and offset |
| center_i | input | FREQ_W | Centre (free-running) frequency word |
| gain_i | input | GAIN_W | Unsigned gain, frequency units per control step |
| bias_i | input | BIAS_W | Signed offset added to the limited control |
| freq_o | output | FREQ_W | Registered frequency word (demodulated frequency) |
| phase_o | output | PHASE_W | Phase accumulator |
| clk_o | output | 1 | Recovered square-wave clock (phase MSB) |
| wrap_o | output | 1 | One-cycle strobe on phase wrap |

## Verification
The assertions take for granted that the release of rst_n is already aligned to the clock. They also assume that the control, mode and configuration inputs are stable around each rising edge. Their stability checks only claim a constant frequency across cycles in which the effective control stays pinned and no load occurred. The bench changes every input on the falling edge and releases reset there. It sweeps the full control range under several configurations, including offsets that straddle both saturation limits, so each assertion antecedent is met many times.

// File: rtl/nco_pkg.sv
package nco_pkg;
  typedef enum logic [1:0] {
    CTRL_LINEAR = 2'd0,
    CTRL_BANG   = 2'd1,
    CTRL_MID    = 2'd2
  } ctrl_mode_e;
endpackage

// File: rtl/nco_ctrl_shaper.sv
module nco_ctrl_shaper
  import nco_pkg::*;
#(
  parameter int CTRL_W     = 8,
  parameter int FULL_SCALE = 100
) (
  input  logic signed [CTRL_W-1:0] ctrl_i,
  input  logic                     los_i,
  input  logic                     bang_i,
  output logic signed [CTRL_W-1:0] ctrl_o
);
  localparam logic signed [CTRL_W-1:0] POS_FS = CTRL_W'(FULL_SCALE);
  localparam logic signed [CTRL_W-1:0] NEG_FS = -POS_FS;

  ctrl_mode_e mode;

  // loss of signal outranks bang-bang
  always_comb begin
    mode = CTRL_LINEAR;
    if (los_i)       mode = CTRL_MID;
    else if (bang_i) mode = CTRL_BANG;
  end

  always_comb begin
    unique case (mode)
      CTRL_MID:  ctrl_o = '0;
      CTRL_BANG: ctrl_o = ctrl_i[CTRL_W-1] ? NEG_FS : POS_FS;
      default: begin
        if (ctrl_i >= POS_FS)      ctrl_o = POS_FS;
        else if (ctrl_i <= NEG_FS) ctrl_o = NEG_FS;
        else                       ctrl_o = ctrl_i;
      end
    endcase
  end
endmodule

// File: rtl/nco_freq_map.sv
module nco_freq_map #(
  parameter int                 CTRL_W     = 8,
  parameter int                 GAIN_W     = 8,
  parameter int                 BIAS_W     = 8,
  parameter int                 FREQ_W     = 12,
  parameter logic [FREQ_W-1:0]  DEF_CENTER = '0,
  parameter logic [GAIN_W-1:0]  DEF_GAIN   = '0,
  parameter logic [BIAS_W-1:0]  DEF_BIAS   = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [CTRL_W-1:0] ctrl_i,
  input  logic                     cfg_load_i,
  input  logic [FREQ_W-1:0]        center_i,
  input  logic [GAIN_W-1:0]        gain_i,
  input  logic signed [BIAS_W-1:0] bias_i,
  output logic [FREQ_W-1:0]        freq_o
);
  localparam int EFF_W  = ((CTRL_W > BIAS_W) ? CTRL_W : BIAS_W) + 1;
  localparam int PROD_W = EFF_W + GAIN_W + 1;
  localparam int SUM_W  = ((PROD_W > FREQ_W + 1) ? PROD_W : FREQ_W + 1) + 1;
  localparam logic signed [SUM_W-1:0] SUM_MAX = $signed(SUM_W'({FREQ_W{1'b1}}));

  logic [FREQ_W-1:0]        center_q, center_d;
  logic [GAIN_W-1:0]        gain_q, gain_d;
  logic signed [BIAS_W-1:0] bias_q, bias_d;
  logic [FREQ_W-1:0]        freq_q, freq_d;
  logic signed [SUM_W-1:0]  eff_s, gain_s, cen_s, sum_s;

  // configuration next state: load strobe is the only enable
  always_comb begin
    center_d = center_q;
    gain_d   = gain_q;
    bias_d   = bias_q;
    if (cfg_load_i) begin
      center_d = center_i;
      gain_d   = gain_i;
      bias_d   = bias_i;
    end
  end

  // offset joins the already limited control, then scale and saturate
  always_comb begin
    eff_s  = SUM_W'(ctrl_i) + SUM_W'(bias_q);
    gain_s = $signed(SUM_W'(gain_q));
    cen_s  = $signed(SUM_W'(center_q));
    sum_s  = cen_s + eff_s * gain_s;
    if (sum_s < 0)            freq_d = '0;
    else if (sum_s > SUM_MAX) freq_d = '1;
    else                      freq_d = sum_s[FREQ_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      center_q <= DEF_CENTER;
      gain_q   <= DEF_GAIN;
      bias_q   <= $signed(DEF_BIAS);
      freq_q   <= '0;
    end else begin
      center_q <= center_d;
      gain_q   <= gain_d;
      bias_q   <= bias_d;
      freq_q   <= freq_d;
    end
  end

  assign freq_o = freq_q;
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int PHASE_W = 16,
  parameter int FREQ_W  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FREQ_W-1:0]  freq_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic               wrap_o
);
  localparam int EXT_W = PHASE_W + 1;

  logic [PHASE_W-1:0] phase_q, phase_d;
  logic               wrap_q, wrap_d;
  logic [EXT_W-1:0]   sum_w;

  always_comb begin
    sum_w   = {1'b0, phase_q} + EXT_W'(freq_i);
    phase_d = sum_w[PHASE_W-1:0];
    wrap_d  = sum_w[PHASE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      wrap_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      wrap_q  <= wrap_d;
    end
  end

  assign phase_o = phase_q;
  assign wrap_o  = wrap_q;
endmodule

// File: rtl/nco_sat_top.sv
module nco_sat_top #(
  parameter int                CTRL_W     = 8,
  parameter int                FULL_SCALE = 100,
  parameter int                GAIN_W     = 8,
  parameter int                BIAS_W     = 8,
  parameter int                FREQ_W     = 12,
  parameter int                PHASE_W    = 16,
  parameter logic [FREQ_W-1:0] DEF_CENTER = 12'd2048,
  parameter logic [GAIN_W-1:0] DEF_GAIN   = 8'd10,
  parameter logic [BIAS_W-1:0] DEF_BIAS   = 8'd0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [CTRL_W-1:0] ctrl_i,
  input  logic                     los_i,
  input  logic                     bang_i,
  input  logic                     cfg_load_i,
  input  logic [FREQ_W-1:0]        center_i,
  input  logic [GAIN_W-1:0]        gain_i,
  input  logic signed [BIAS_W-1:0] bias_i,
  output logic [FREQ_W-1:0]        freq_o,
  output logic [PHASE_W-1:0]       phase_o,
  output logic                     clk_o,
  output logic                     wrap_o
);
  logic signed [CTRL_W-1:0] ctrl_lim;

  nco_ctrl_shaper #(
    .CTRL_W(CTRL_W), .FULL_SCALE(FULL_SCALE)
  ) u_shaper (
    .ctrl_i(ctrl_i), .los_i(los_i), .bang_i(bang_i), .ctrl_o(ctrl_lim)
  );

  nco_freq_map #(
    .CTRL_W(CTRL_W), .GAIN_W(GAIN_W), .BIAS_W(BIAS_W), .FREQ_W(FREQ_W),
    .DEF_CENTER(DEF_CENTER), .DEF_GAIN(DEF_GAIN), .DEF_BIAS(DEF_BIAS)
  ) u_freq (
    .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl_lim), .cfg_load_i(cfg_load_i),
    .center_i(center_i), .gain_i(gain_i), .bias_i(bias_i), .freq_o(freq_o)
  );

  nco_phase_acc #(
    .PHASE_W(PHASE_W), .FREQ_W(FREQ_W)
  ) u_acc (
    .clk(clk), .rst_n(rst_n), .freq_i(freq_o), .phase_o(phase_o), .wrap_o(wrap_o)
  );

  assign clk_o = phase_o[PHASE_W-1];
endmodule

// File: rtl/nco_sat_chk.sv
module nco_sat_chk #(
  parameter int CTRL_W     = 8,
  parameter int FULL_SCALE = 100,
  parameter int FREQ_W     = 12,
  parameter int PHASE_W    = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic signed [CTRL_W-1:0] ctrl_i,
  input logic                     los_i,
  input logic                     bang_i,
  input logic                     cfg_load_i,
  input logic [FREQ_W-1:0]        freq_o,
  input logic [PHASE_W-1:0]       phase_o,
  input logic                     wrap_o
);
  localparam logic signed [CTRL_W-1:0] POS_FS = CTRL_W'(FULL_SCALE);

  logic up_q;
  logic pinned_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_q <= 1'b0;
    else        up_q <= 1'b1;
  end

  assign pinned_hi = !los_i && ((!bang_i && ctrl_i >= POS_FS) ||
                                (bang_i && !ctrl_i[CTRL_W-1]));

  // R4 R7
  pinned_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && pinned_hi && $past(pinned_hi) && !$past(cfg_load_i)) |=> $stable(freq_o));

  // R6
  los_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && los_i && $past(los_i) && !$past(cfg_load_i)) |=> $stable(freq_o));

  // R9
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (phase_o == PHASE_W'($past(phase_o) + PHASE_W'($past(freq_o)))));

  // R10
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |-> (phase_o < $past(phase_o)));

  // R10
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_o |-> (phase_o >= $past(phase_o)));
endmodule

bind nco_sat_top nco_sat_chk #(
  .CTRL_W(CTRL_W), .FULL_SCALE(FULL_SCALE), .FREQ_W(FREQ_W), .PHASE_W(PHASE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl_i), .los_i(los_i), .bang_i(bang_i),
  .cfg_load_i(cfg_load_i), .freq_o(freq_o), .phase_o(phase_o), .wrap_o(wrap_o)
);

// File: tb/test_nco_sat_top.sv
`timescale 1ns/1ps
module test_nco_sat_top;
  localparam int FS    = 100;
  localparam int FMAX  = 4095;
  localparam int PMOD  = 65536;

  logic              clk = 1'b0;
  logic              rst_n;
  logic signed [7:0] ctrl_i;
  logic              los_i, bang_i, cfg_load_i;
  logic [11:0]       center_i;
  logic [7:0]        gain_i;
  logic signed [7:0] bias_i;
  logic [11:0]       freq_o;
  logic [15:0]       phase_o;
  logic              clk_o, wrap_o;

  int n_cmp = 0, n_bad = 0;
  int exp_freq = 0, exp_phase = 0, exp_wrap = 0;
  int cur_cen = 2048, cur_gain = 10, cur_bias = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  nco_sat_top #(
    .CTRL_W(8), .FULL_SCALE(FS), .GAIN_W(8), .BIAS_W(8), .FREQ_W(12), .PHASE_W(16),
    .DEF_CENTER(12'd2048), .DEF_GAIN(8'd10), .DEF_BIAS(8'd0)
  ) i_nco_sat_top (
    .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl_i), .los_i(los_i), .bang_i(bang_i),
    .cfg_load_i(cfg_load_i), .center_i(center_i), .gain_i(gain_i), .bias_i(bias_i),
    .freq_o(freq_o), .phase_o(phase_o), .clk_o(clk_o), .wrap_o(wrap_o)
  );

  function automatic int model(int c_raw, bit los, bit bb, int cen, int g, int b);
    int c;
    int f;
    if (los)              c = 0;
    else if (bb)          c = (c_raw < 0) ? -FS : FS;
    else if (c_raw >= FS) c = FS;
    else if (c_raw <= -FS) c = -FS;
    else                  c = c_raw;
    f = cen + g * (c + b);
    if (f < 0)    f = 0;
    if (f > FMAX) f = FMAX;
    return f;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic string tag_for(int v);
    int f;
    f = model(v, los_i, bang_i, cur_cen, cur_gain, cur_bias);
    if (los_i)                 return "R6";
    if (bang_i)                return "R7";
    if (f == 0 || f == FMAX)   return "R5";
    if (v == 0 && cur_bias == 0) return "R3";
    if (v >= FS || v <= -FS)   return "R4";
    return "R2";
  endfunction

  task automatic step(string tag);
    int nsum;
    nsum      = exp_phase + exp_freq;
    exp_wrap  = (nsum >= PMOD) ? 1 : 0;
    exp_phase = nsum % PMOD;
    exp_freq  = model(int'(ctrl_i), los_i, bang_i, cur_cen, cur_gain, cur_bias);
    if (cfg_load_i) begin
      cur_cen  = int'(center_i);
      cur_gain = int'(gain_i);
      cur_bias = int'(bias_i);
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, int'(freq_o), exp_freq);
    chk("R9 phase", int'(phase_o), exp_phase);
    chk("R9 clk", int'(clk_o), exp_phase >> 15);
    chk("R10 wrap", int'(wrap_o), exp_wrap);
  endtask

  task automatic sweep();
    for (int v = -128; v <= 127; v++) begin
      ctrl_i = 8'(v);
      step(tag_for(v));
    end
  endtask

  task automatic load_cfg(int cen, int g, int b);
    center_i = 12'(cen); gain_i = 8'(g); bias_i = 8'(b);
    cfg_load_i = 1'b1; ctrl_i = '0;
    step("R11");
    cfg_load_i = 1'b0;
    step("R11");
  endtask

  initial begin
    rst_n = 1'b0; ctrl_i = '0; los_i = 0; bang_i = 0; cfg_load_i = 0;
    center_i = '0; gain_i = '0; bias_i = '0;
    repeat (3) @(negedge clk);
    chk("R1 freq", int'(freq_o), 0);
    chk("R1 phase", int'(phase_o), 0);
    chk("R1 clk", int'(clk_o), 0);
    chk("R1 wrap", int'(wrap_o), 0);
    rst_n = 1'b1;
    ctrl_i = '0;
    step("R1 default centre");
    sweep();
    // R8: alternate the extremes each cycle
    for (int k = 0; k < 8; k++) begin
      ctrl_i = (k % 2 == 0) ? 8'sd127 : -8'sd128;
      step("R8");
    end
    // R11: configuration inputs move without a load and must be ignored
    center_i = 12'd500; gain_i = 8'd77; bias_i = -8'sd9;
    for (int v = -3; v <= 3; v++) begin
      ctrl_i = 8'(v);
      step("R11");
    end
    load_cfg(100, 40, -3);
    sweep();
    load_cfg(3000, 20, 5);
    sweep();
    load_cfg(2000, 5, 20);
    sweep();
    los_i = 1'b1;
    sweep();
    bang_i = 1'b1;
    sweep();
    los_i = 1'b0;
    sweep();
    bang_i = 1'b0;
    load_cfg(1000, 3, 0);
    sweep();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R9 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule